// File: doc/BRIEF.md
# Vectored Interrupt Routing Controller

This block gathers interrupt events from three places into one 32-vector pending set. Software can raise vectors by writing ones to a set register. Local and remote serial link errors each raise a fixed vector. Interrupt status words that arrive from the far end of the link are written into whichever register the pointer register names.

One control bit decides where the pending vectors go. In local mode they land in a status register, and the local interrupt line is the OR of that register. In forward mode they are offered to the link transmitter as a 32-bit interrupt word, using a request/acknowledge handshake. Once the transmitter takes a word, the vectors it carried are cleared.

A priority register reports the lowest-numbered active vector, which has the highest priority. Writing a vector number to the priority register clears that one vector.

Register port (word index on `reg_addr`): 0 control (bit 0 = local mode), 1 status (write-1-to-clear), 2 pending (write-1-to-set), 3 priority, 4 pointer (3 bits). Reads are combinational.

Top module: `irq_router`

## Requirements
- R1: After reset the following hold: control reads 0 (forward mode), status reads 0, pending reads 0, pointer reads 2, `irq_out` is 0, `tx_req` is 0 and priority reads 32'h8000_0000.
- R2: Writing to pending (index 2) sets every vector whose data bit is 1 and leaves the others unchanged. In forward mode the set bits read back from pending. In local mode they appear in status at the same clock edge, and pending reads 0.
- R3: In local mode `irq_out` equals the OR of all status bits. Writing 1s to status (index 1) clears those bits. No forward request starts while local mode is set.
- R4: In forward mode, a nonzero pending set raises `tx_req` one clock edge later, with `tx_status` holding a snapshot of the pending vectors. Both are held unchanged until `tx_ack` is seen high.
- R5: On the edge where `tx_req` and `tx_ack` are both high, `tx_req` drops and the snapshot vectors are cleared from pending. Vectors set while waiting stay pending and are offered in the next request.
- R6: While `link_err_loc` is high, vector 30 is set. While `link_err_rem` is high, vector 31 is set.
- R7: Priority (index 3) reads the index of the lowest-numbered vector active in status or pending. If none is active it reads 32'h8000_0000.
- R8: Writing to priority clears the single vector named by data bits 4:0 in both status and pending. Data bits 31:5 are ignored.
- R9: A received word (`rx_irq_valid`) is ORed into status when the pointer is 1. It goes through the set path (routed as in R2) when the pointer is 2. It is discarded for any other pointer value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| link_err_loc | input | 1 | Local link error condition |
| link_err_rem | input | 1 | Error indication reported by far end |
| rx_irq_valid | input | 1 | Received interrupt word strobe |
| rx_irq_status | input | 32 | Received interrupt word |
| tx_req | output | 1 | Interrupt word ready for transmission |
| tx_status | output | 32 | Interrupt word to transmit |
| tx_ack | input | 1 | Transmitter has taken the word |
| irq_out | output | 1 | Local interrupt line |

## Verification
The bench sets a new vector while a forward request is still waiting for its acknowledge. A design that cleared the whole pending set on acknowledge would lose that vector. A design that reloaded the snapshot mid-wait would change `tx_status` under the transmitter. The priority clear is written with junk in the upper data bits, which catches a decoder that looks at the full word. Vector 0 is cleared while absent, and the empty encoding is checked directly. The remote word is driven under three pointer values, including one that must discard it. A design that routed by default would show the stray bits in status.

// File: rtl/irq_router.sv
module irq_router #(
  parameter int NVEC     = 32,
  parameter int LERR_VEC = 30,
  parameter int RERR_VEC = 31
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        link_err_loc,
  input  logic        link_err_rem,
  input  logic        rx_irq_valid,
  input  logic [31:0] rx_irq_status,
  output logic        tx_req,
  output logic [31:0] tx_status,
  input  logic        tx_ack,
  output logic        irq_out
);
  localparam int VW = $clog2(NVEC);
  localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_PEND = 3'd2,
                         A_PRIO = 3'd3, A_PTR = 3'd4;

  logic            local_mode, busy;
  logic [2:0]      ptr;
  logic [NVEC-1:0] stat, pend, snap;
  logic [NVEC-1:0] err_vec, set_vec, rx_stat, w1c, clr, sent, active;
  logic [VW-1:0]   prio_idx;

  wire wr_ctrl = reg_we && reg_addr == A_CTRL;
  wire wr_prio = reg_we && reg_addr == A_PRIO;
  wire fire    = busy && tx_ack;

  always_comb begin
    err_vec = '0;
    err_vec[LERR_VEC] = link_err_loc;
    err_vec[RERR_VEC] = err_vec[RERR_VEC] | link_err_rem;
  end

  assign set_vec = err_vec
                 | ((reg_we && reg_addr == A_PEND) ? reg_wdata[NVEC-1:0] : '0)
                 | ((rx_irq_valid && ptr == A_PEND) ? rx_irq_status[NVEC-1:0] : '0);
  assign rx_stat = (rx_irq_valid && ptr == A_STAT) ? rx_irq_status[NVEC-1:0] : '0;
  assign w1c     = (reg_we && reg_addr == A_STAT) ? reg_wdata[NVEC-1:0] : '0;
  assign clr     = wr_prio ? (NVEC'(1) << reg_wdata[VW-1:0]) : '0;
  assign sent    = fire ? snap : '0;
  assign active  = stat | pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      local_mode <= 1'b0;
      ptr        <= A_PEND;
      stat       <= '0;
      pend       <= '0;
      snap       <= '0;
      busy       <= 1'b0;
    end else begin
      if (wr_ctrl) local_mode <= reg_wdata[0];
      if (reg_we && reg_addr == A_PTR) ptr <= reg_wdata[2:0];
      if (local_mode) begin
        stat <= (stat & ~w1c & ~clr) | (pend & ~clr) | set_vec | rx_stat;
        pend <= '0;
      end else begin
        stat <= (stat & ~w1c & ~clr) | rx_stat;
        pend <= (pend & ~clr & ~sent) | set_vec;
      end
      if (fire) busy <= 1'b0;
      else if (!busy && !local_mode && pend != '0) begin
        busy <= 1'b1;
        snap <= pend;
      end
    end
  end

  always_comb begin
    prio_idx = '0;
    for (int i = NVEC - 1; i >= 0; i--)
      if (active[i]) prio_idx = VW'(i);
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {31'b0, local_mode};
      A_STAT:  reg_rdata = 32'(stat);
      A_PEND:  reg_rdata = 32'(pend);
      A_PRIO:  reg_rdata = (active == '0) ? 32'h8000_0000 : 32'(prio_idx);
      A_PTR:   reg_rdata = {29'b0, ptr};
      default: reg_rdata = '0;
    endcase
  end

  assign tx_req    = busy;
  assign tx_status = 32'(snap);
  assign irq_out   = |stat;

  // R4
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req && !tx_ack |=> tx_req && $stable(tx_status));
  // R5
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req && tx_ack |=> !tx_req);
  // R3
  local_no_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_req) |-> $past(!local_mode));
  // R2
  local_pend_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    local_mode && !wr_ctrl |=> pend == '0);
  // R8
  prio_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_prio && set_vec == '0 && rx_stat == '0 |=> !active[$past(reg_wdata[VW-1:0])]);
endmodule

// File: tb/irq_router_test.sv
module irq_router_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd7;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        link_err_loc = 1'b0, link_err_rem = 1'b0;
  logic        rx_irq_valid = 1'b0;
  logic [31:0] rx_irq_status = '0;
  logic        tx_req, tx_ack = 1'b0, irq_out;
  logic [31:0] tx_status;
  int          n_chk = 0, n_fail = 0;
  logic [31:0] rv;

  irq_router uut (.*);

  always #10 clk = ~clk;

  // entry: {req[3:0], waddr[2:0], wdata[31:0], raddr[2:0], exp[31:0]}
  localparam int NT = 11;
  localparam logic [73:0] TBL [0:NT-1] = '{
    {4'd3, 3'd0, 32'h0000_0001, 3'd0, 32'h0000_0001},  // R3 enter local
    {4'd2, 3'd2, 32'h0000_0012, 3'd1, 32'h0000_0012},  // R2 set lands in status
    {4'd2, 3'd2, 32'h0000_0000, 3'd2, 32'h0000_0000},  // R2 pending empty in local
    {4'd3, 3'd1, 32'h0000_0002, 3'd1, 32'h0000_0010},  // R3 write-1-to-clear
    {4'd7, 3'd3, 32'h0000_0000, 3'd3, 32'h0000_0004},  // R7 lowest index
    {4'd7, 3'd2, 32'h8000_0000, 3'd3, 32'h0000_0004},  // R7 priority kept
    {4'd8, 3'd3, 32'hFFFF_FFE4, 3'd1, 32'h8000_0000},  // R8 upper bits ignored
    {4'd7, 3'd3, 32'h0000_0000, 3'd3, 32'h0000_001F},  // R7 vector 31
    {4'd7, 3'd1, 32'hFFFF_FFFF, 3'd3, 32'h8000_0000},  // R7 empty mark
    {4'd2, 3'd0, 32'h0000_0000, 3'd0, 32'h0000_0000},  // R2 back to forward
    {4'd2, 3'd2, 32'h0000_0300, 3'd2, 32'h0000_0300}   // R2 forward accumulates
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 3'd7;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #2 d = reg_rdata;
    reg_addr = 3'd7;
  endtask

  task automatic rx_pulse(input logic [31:0] w);
    @(negedge clk);
    rx_irq_valid = 1'b1; rx_irq_status = w;
    @(negedge clk);
    rx_irq_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(3'd0, rv); chk("R1 ctrl", rv, 32'h0);
    rd(3'd1, rv); chk("R1 status", rv, 32'h0);
    rd(3'd2, rv); chk("R1 pending", rv, 32'h0);
    rd(3'd4, rv); chk("R1 pointer", rv, 32'h2);
    rd(3'd3, rv); chk("R1 priority", rv, 32'h8000_0000);
    chk("R1 irq_out", {31'b0, irq_out}, 32'h0);
    chk("R1 tx_req", {31'b0, tx_req}, 32'h0);

    for (int i = 0; i < NT; i++) begin
      wr(TBL[i][69:67], TBL[i][66:35]);
      rd(TBL[i][34:32], rv);
      n_chk++;
      if (rv !== TBL[i][31:0]) begin
        n_fail++;
        $display("FAIL R%0d table[%0d] actual=%h expected=%h", TBL[i][73:70], i, rv, TBL[i][31:0]);
      end
    end

    // R4 request and hold
    @(negedge clk);
    chk("R4 tx_req raised", {31'b0, tx_req}, 32'h1);
    chk("R4 snapshot", tx_status, 32'h0000_0300);
    wr(3'd2, 32'h0000_0001);
    repeat (3) @(negedge clk);
    chk("R4 tx_req held", {31'b0, tx_req}, 32'h1);
    chk("R4 snapshot held", tx_status, 32'h0000_0300);
    rd(3'd2, rv); chk("R5 pending while waiting", rv, 32'h0000_0301);
    // R5 acknowledge
    @(negedge clk); tx_ack = 1'b1;
    @(negedge clk); tx_ack = 1'b0;
    chk("R5 tx_req dropped", {31'b0, tx_req}, 32'h0);
    rd(3'd2, rv); chk("R5 late vector kept", rv, 32'h0000_0001);
    @(negedge clk);
    chk("R5 next request", {31'b0, tx_req}, 32'h1);
    chk("R5 next snapshot", tx_status, 32'h0000_0001);
    @(negedge clk); tx_ack = 1'b1;
    @(negedge clk); tx_ack = 1'b0;
    rd(3'd2, rv); chk("R5 pending cleared", rv, 32'h0);

    // R6 link errors, local mode
    wr(3'd0, 32'h1);
    @(negedge clk); link_err_loc = 1'b1;
    @(negedge clk); link_err_loc = 1'b0;
    rd(3'd1, rv); chk("R6 local error vector", rv, 32'h4000_0000);
    chk("R3 irq_out set", {31'b0, irq_out}, 32'h1);
    @(negedge clk); link_err_rem = 1'b1;
    @(negedge clk); link_err_rem = 1'b0;
    rd(3'd1, rv); chk("R6 remote error vector", rv, 32'hC000_0000);
    chk("R3 no request in local", {31'b0, tx_req}, 32'h0);
    wr(3'd1, 32'hFFFF_FFFF);
    chk("R3 irq_out cleared", {31'b0, irq_out}, 32'h0);

    // R9 remote status pointer
    wr(3'd4, 32'h1);
    rx_pulse(32'h0000_00F0);
    rd(3'd1, rv); chk("R9 pointer to status", rv, 32'h0000_00F0);
    wr(3'd4, 32'h4);
    rx_pulse(32'h0000_000F);
    rd(3'd1, rv); chk("R9 discarded status", rv, 32'h0000_00F0);
    rd(3'd2, rv); chk("R9 discarded pending", rv, 32'h0);
    wr(3'd4, 32'h2);
    rx_pulse(32'h0000_0001);
    rd(3'd1, rv); chk("R9 pointer to pending", rv, 32'h0000_00F1);

    // R1 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    rd(3'd1, rv); chk("R1 status after reset", rv, 32'h0);
    rd(3'd0, rv); chk("R1 ctrl after reset", rv, 32'h0);
    rd(3'd4, rv); chk("R1 pointer after reset", rv, 32'h2);
    chk("R1 irq_out after reset", {31'b0, irq_out}, 32'h0);
    rst_n = 1'b1;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule